// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in a speculative out-of-order core. When an instruction leaves decode it claims the next free slot of a circular buffer. The slot number goes back to the issuing logic and serves as the tag of that instruction's result. Execution units finish in any order and post their results on a shared result bus under that tag. The buffer records each result in the matching slot and marks the slot complete.

Retirement happens only at the oldest slot, and only once that slot is complete. The action depends on the kind stored at issue. A register-writing instruction produces a register-file write strobe. A store produces a memory write strobe. A correctly predicted branch simply leaves the buffer. A mispredicted branch drives a redirect with the correct successor address, and in the same cycle the whole buffer is emptied, so every younger speculative instruction is dropped. At most one instruction retires per cycle.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty (`robEmpty`=1), `issueReady`=1, `issueTag`=0, and `regWrEn`, `memWrEn` and `redirectValid` are all 0.
- R2: Each accepted issue takes the slot shown on `issueTag`, and tags advance by one modulo 16 (15 wraps to 0). With 16 instructions in flight, `issueReady` is 0 and any issue request is ignored.
- R3: A result bus write with `cdbValid`=1 stores `cdbValue`, `cdbAux` and `cdbMispredict` in the slot named by `cdbTag` and marks it complete. A slot that is not complete never retires.
- R4: Retirement is strictly in issue order. A complete younger slot waits while any older slot is incomplete.
- R5: A result written to the oldest slot during a cycle makes it retire in the following cycle. The retirement outputs stay 0 during the write cycle itself.
- R6: When the oldest complete slot has kind 2'b00 (register), `regWrEn`=1 with `regWrIdx` set to its destination and `regWrData` set to its result.
- R7: When the oldest complete slot has kind 2'b01 (store), `memWrEn`=1 with `memWrAddr` set to its aux field and `memWrData` set to its result. `regWrEn` stays 0.
- R8: When the oldest complete slot has kind 2'b10 (branch) and its mispredict flag is 0, it retires with no register write, no memory write and no redirect.
- R9: When the oldest complete slot is a branch with its mispredict flag set to 1, `redirectValid`=1 and `redirectPc` equals its aux field. At the next edge every slot is discarded, the buffer becomes empty with the next tag 0, and an issue requested in that cycle is dropped.
- R10: At most one of `regWrEn`, `memWrEn` and `redirectValid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issueValid | input | 1 | Request to allocate a slot |
| issueKind | input | 2 | 00 register, 01 store, 10 branch |
| issueDest | input | 5 | Destination architectural register |
| issueReady | output | 1 | A slot is free |
| issueTag | output | 4 | Slot index granted to the current request |
| cdbValid | input | 1 | Result bus write |
| cdbTag | input | 4 | Slot that the result belongs to |
| cdbValue | input | 32 | Result value, or store data |
| cdbAux | input | 32 | Store address, or branch correct successor |
| cdbMispredict | input | 1 | Branch resolved against its prediction |
| regWrEn | output | 1 | Register-file write strobe |
| regWrIdx | output | 5 | Register-file write index |
| regWrData | output | 32 | Register-file write data |
| memWrEn | output | 1 | Memory store strobe |
| memWrAddr | output | 32 | Store address |
| memWrData | output | 32 | Store data |
| redirectValid | output | 1 | Fetch redirect after a misprediction |
| redirectPc | output | 32 | Redirect target |
| robEmpty | output | 1 | No instruction in flight |

## Verification
The assertions assume a well-behaved environment. Issue is requested only while `issueReady` is high, except in deliberate probes. The result bus never names a free slot, and it writes each occupied slot at most once. The directed tests follow these rules. They allocate a known set of slots, then post exactly one result per allocated tag, and they choose the posting order on purpose to reach out-of-order completion, same-cycle completion at the oldest slot, and a flush. The probes that request issue while full, or during a flush cycle, are checked through `robEmpty` and `issueTag` afterwards.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } robKind_e;

  // Strobes from control to storage, one cycle each.
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  input  logic             headValid,
  input  logic             headReady,
  input  robKind_e         headKind,
  input  logic             headMispredict,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] tailIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             issueReady,
  output logic             robEmpty
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] occCount;
  logic             isFull;
  logic             retireNow;
  logic             flushNow;
  logic             allocNow;

  assign isFull     = (occCount == FULL_CNT);
  assign robEmpty   = (occCount == '0);
  assign issueReady = !isFull;

  assign retireNow = !robEmpty && headValid && headReady;
  assign flushNow  = retireNow && (headKind == KIND_BRANCH) && headMispredict;
  assign allocNow  = issueValid && !isFull && !flushNow;

  assign strobe.alloc  = allocNow;
  assign strobe.retire = retireNow && !flushNow;
  assign strobe.flush  = flushNow;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headIdx  <= '0;
      tailIdx  <= '0;
      occCount <= '0;
    end else if (flushNow) begin
      headIdx  <= '0;
      tailIdx  <= '0;
      occCount <= '0;
    end else begin
      if (allocNow) tailIdx <= bump(tailIdx);
      if (retireNow) headIdx <= bump(headIdx);
      case ({allocNow, retireNow})
        2'b10:   occCount <= occCount + 1'b1;
        2'b01:   occCount <= occCount - 1'b1;
        default: occCount <= occCount;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occCount <= FULL_CNT);

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(isFull) && !$past(retireNow) |-> tailIdx == $past(tailIdx) || robEmpty);

  p_head_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.retire) |-> headIdx == bump($past(headIdx)));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> robEmpty && headIdx == '0 && tailIdx == '0);

endmodule

// File: rtl/rob_datapath.sv
module rob_datapath
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  robKind_e          allocKind,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              cdbValid,
  input  logic [IDX_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic [DATA_W-1:0] cdbAux,
  input  logic              cdbMispredict,
  output logic              headValid,
  output logic              headReady,
  output robKind_e          headKind,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic [DATA_W-1:0] headAux,
  output logic              headMispredict
);

  logic [DEPTH-1:0]  slotValid;
  logic [DEPTH-1:0]  slotReady;
  logic [DEPTH-1:0]  slotMiss;
  robKind_e          slotKind  [DEPTH];
  logic [REG_W-1:0]  slotDest  [DEPTH];
  logic [DATA_W-1:0] slotValue [DEPTH];
  logic [DATA_W-1:0] slotAux   [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic allocHit;
    logic retireHit;
    logic cdbHit;
    assign allocHit  = strobe.alloc  && (tailIdx == IDX_W'(gi));
    assign retireHit = strobe.retire && (headIdx == IDX_W'(gi));
    assign cdbHit    = cdbValid && (cdbTag == IDX_W'(gi)) && slotValid[gi];

    always_ff @(posedge clk) begin
      if (!rst_n || strobe.flush) begin
        slotValid[gi] <= 1'b0;
        slotReady[gi] <= 1'b0;
        slotMiss[gi]  <= 1'b0;
      end else if (allocHit) begin
        slotValid[gi] <= 1'b1;
        slotReady[gi] <= 1'b0;
        slotMiss[gi]  <= 1'b0;
      end else if (retireHit) begin
        slotValid[gi] <= 1'b0;
        slotReady[gi] <= 1'b0;
      end else if (cdbHit) begin
        slotReady[gi] <= 1'b1;
        slotMiss[gi]  <= cdbMispredict;
      end
    end

    always_ff @(posedge clk) begin
      if (allocHit) begin
        slotKind[gi] <= allocKind;
        slotDest[gi] <= allocDest;
      end
      if (cdbHit) begin
        slotValue[gi] <= cdbValue;
        slotAux[gi]   <= cdbAux;
      end
    end
  end

  assign headValid      = slotValid[headIdx];
  assign headReady      = slotReady[headIdx];
  assign headKind       = slotKind[headIdx];
  assign headDest       = slotDest[headIdx];
  assign headValue      = slotValue[headIdx];
  assign headAux        = slotAux[headIdx];
  assign headMispredict = slotMiss[headIdx];

  p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.alloc |-> !slotValid[tailIdx]);

  p_retire_from_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.retire || strobe.flush) |-> headValid && headReady);

  p_cdb_marks_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cdbValid && slotValid[cdbTag] && !strobe.flush && !strobe.retire |=> slotReady[$past(cdbTag)]);

endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [REG_W-1:0]  issueDest,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueTag,
  input  logic              cdbValid,
  input  logic [IDX_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic [DATA_W-1:0] cdbAux,
  input  logic              cdbMispredict,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectPc,
  output logic              robEmpty
);

  robStrobe_t        strobe;
  logic [IDX_W-1:0]  tailIdx;
  logic [IDX_W-1:0]  headIdx;
  logic              headValid;
  logic              headReady;
  robKind_e          headKind;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue;
  logic [DATA_W-1:0] headAux;
  logic              headMispredict;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headMispredict(headMispredict), .strobe(strobe), .tailIdx(tailIdx),
    .headIdx(headIdx), .issueReady(issueReady), .robEmpty(robEmpty)
  );

  rob_datapath #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .tailIdx(tailIdx),
    .headIdx(headIdx), .allocKind(robKind_e'(issueKind)), .allocDest(issueDest),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue), .cdbAux(cdbAux),
    .cdbMispredict(cdbMispredict), .headValid(headValid), .headReady(headReady),
    .headKind(headKind), .headDest(headDest), .headValue(headValue),
    .headAux(headAux), .headMispredict(headMispredict)
  );

  assign issueTag      = tailIdx;
  assign regWrEn       = strobe.retire && (headKind == KIND_REG);
  assign regWrIdx      = headDest;
  assign regWrData     = headValue;
  assign memWrEn       = strobe.retire && (headKind == KIND_STORE);
  assign memWrAddr     = headAux;
  assign memWrData     = headValue;
  assign redirectValid = strobe.flush;
  assign redirectPc    = headAux;

  p_single_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regWrEn, memWrEn, redirectValid}));

  p_redirect_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |=> robEmpty && !regWrEn && !memWrEn);

endmodule

// File: tb/rob_commit_unit_tb.sv
module rob_commit_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueKind = 2'b00;
  logic [4:0]  issueDest = '0;
  logic        issueReady;
  logic [3:0]  issueTag;
  logic        cdbValid = 1'b0;
  logic [3:0]  cdbTag = '0;
  logic [31:0] cdbValue = '0;
  logic [31:0] cdbAux = '0;
  logic        cdbMispredict = 1'b0;
  logic        regWrEn;
  logic [4:0]  regWrIdx;
  logic [31:0] regWrData;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        robEmpty;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rob_commit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueReady(issueReady), .issueTag(issueTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue), .cdbAux(cdbAux),
    .cdbMispredict(cdbMispredict), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .robEmpty(robEmpty)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance one edge and settle; every sample also checks R10.
  task automatic tick();
    @(posedge clk);
    #1;
    chk("R10", "one action", 32'(int'(regWrEn) + int'(memWrEn) + int'(redirectValid) <= 1), 32'd1);
  endtask

  task automatic issueOne(input logic [1:0] kind, input logic [4:0] dest, input logic [3:0] expTag);
    chk("R2", "issueReady", 32'(issueReady), 32'd1);
    chk("R2", "issueTag", 32'(issueTag), 32'(expTag));
    issueValid = 1'b1; issueKind = kind; issueDest = dest;
    tick();
    issueValid = 1'b0;
  endtask

  task automatic postResult(input logic [3:0] tag, input logic [31:0] val, input logic [31:0] aux, input logic mis);
    cdbValid = 1'b1; cdbTag = tag; cdbValue = val; cdbAux = aux; cdbMispredict = mis;
    tick();
    cdbValid = 1'b0; cdbMispredict = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [4:0] dest, input logic [31:0] val);
    chk(req, "regWrEn", 32'(regWrEn), 32'd1);
    chk(req, "regWrIdx", 32'(regWrIdx), 32'(dest));
    chk(req, "regWrData", regWrData, val);
  endtask

  task automatic testReset();
    chk("R1", "robEmpty", 32'(robEmpty), 32'd1);
    chk("R1", "issueReady", 32'(issueReady), 32'd1);
    chk("R1", "issueTag", 32'(issueTag), 32'd0);
    chk("R1", "no action", 32'({regWrEn, memWrEn, redirectValid}), 32'd0);
  endtask

  task automatic testOrder();
    issueOne(2'b00, 5'd3, 4'd0);
    issueOne(2'b00, 5'd4, 4'd1);
    issueOne(2'b00, 5'd5, 4'd2);
    postResult(4'd2, 32'hC2, 32'h0, 1'b0);
    chk("R4", "young ready waits", 32'(regWrEn), 32'd0);
    postResult(4'd1, 32'hC1, 32'h0, 1'b0);
    chk("R3", "head incomplete", 32'(regWrEn), 32'd0);
    cdbValid = 1'b1; cdbTag = 4'd0; cdbValue = 32'hC0; cdbAux = '0;
    #1;
    chk("R5", "no retire in write cycle", 32'(regWrEn), 32'd0);
    tick();
    cdbValid = 1'b0;
    expectReg("R5", 5'd3, 32'hC0);
    tick();
    expectReg("R4", 5'd4, 32'hC1);
    tick();
    expectReg("R6", 5'd5, 32'hC2);
    tick();
    chk("R4", "drained", 32'(robEmpty), 32'd1);
    chk("R4", "no retire", 32'(regWrEn), 32'd0);
  endtask

  task automatic testFlush();
    issueOne(2'b00, 5'd7, 4'd3);
    issueOne(2'b10, 5'd0, 4'd4);
    issueOne(2'b00, 5'd8, 4'd5);
    postResult(4'd5, 32'h55, 32'h0, 1'b0);
    postResult(4'd4, 32'h0, 32'h1234, 1'b1);
    postResult(4'd3, 32'h33, 32'h0, 1'b0);
    expectReg("R6", 5'd7, 32'h33);
    tick();
    chk("R9", "redirectValid", 32'(redirectValid), 32'd1);
    chk("R9", "redirectPc", redirectPc, 32'h1234);
    chk("R9", "no reg write", 32'(regWrEn), 32'd0);
    issueValid = 1'b1; issueKind = 2'b00; issueDest = 5'd9;
    tick();
    issueValid = 1'b0;
    chk("R9", "empty after flush", 32'(robEmpty), 32'd1);
    chk("R9", "tag restart", 32'(issueTag), 32'd0);
    chk("R9", "younger dropped", 32'(regWrEn), 32'd0);
    chk("R9", "redirect one cycle", 32'(redirectValid), 32'd0);
    tick();
    chk("R9", "still empty", 32'(robEmpty), 32'd1);
  endtask

  task automatic testFull();
    for (int i = 0; i < 16; i++) issueOne(2'b00, 5'(i + 10), 4'(i));
    chk("R2", "full blocks", 32'(issueReady), 32'd0);
    chk("R2", "empty flag", 32'(robEmpty), 32'd0);
    issueValid = 1'b1; issueKind = 2'b00; issueDest = 5'd31;
    tick();
    issueValid = 1'b0;
    chk("R2", "still full", 32'(issueReady), 32'd0);
    for (int i = 0; i < 16; i++) begin
      postResult(4'(i), 32'(200 + i), 32'h0, 1'b0);
      expectReg("R4", 5'(i + 10), 32'(200 + i));
    end
    tick();
    chk("R2", "extra issue ignored", 32'(robEmpty), 32'd1);
    chk("R2", "no 17th retire", 32'(regWrEn), 32'd0);
    chk("R2", "tag wrapped", 32'(issueTag), 32'd0);
  endtask

  task automatic testStoreBranch();
    issueOne(2'b01, 5'd0, 4'd0);
    issueOne(2'b10, 5'd0, 4'd1);
    postResult(4'd1, 32'h0, 32'hBEEF, 1'b0);
    postResult(4'd0, 32'hDA7A, 32'h400, 1'b0);
    chk("R7", "memWrEn", 32'(memWrEn), 32'd1);
    chk("R7", "memWrAddr", memWrAddr, 32'h400);
    chk("R7", "memWrData", memWrData, 32'hDA7A);
    chk("R7", "no reg write", 32'(regWrEn), 32'd0);
    tick();
    chk("R8", "no action", 32'({regWrEn, memWrEn, redirectValid}), 32'd0);
    chk("R8", "not empty yet", 32'(robEmpty), 32'd0);
    tick();
    chk("R8", "branch retired", 32'(robEmpty), 32'd1);
    chk("R8", "no redirect", 32'(redirectValid), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    testReset();
    testOrder();
    testFlush();
    testFull();
    testStoreBranch();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule